// File: doc/BRIEF.md
# Keyed-Enable Watchdog Timer

This block is a watchdog for a small microcontroller. A 15-bit counter advances on ticks from one of three sources: a slow oscillator tick, the system clock divided by four, or every system clock cycle. When the count reaches a power-of-two period chosen by software, the block raises a one-cycle reset request. Firmware keeps the request from firing by pulsing a clear input, which restarts the count. Writing the period register also restarts it.

Two 8-bit registers sit on a simple write/read port. The period register holds a 3-bit period code. The control register holds a 2-bit source select and a 6-bit enable key. Only two key values are legal: one runs the watchdog and the other halts it. Any other key value is taken as corruption. A reset request then follows on the third slow-oscillator tick after the bad value lands, unless a legal key is written before that tick.

Top module: `keyed_wdt`

## Requirements
- R1: With the system clock selected (source code 10 or 11), the reset request rises exactly P cycles after the edge that clears the count. Period code c gives P = 2^8 for c = 0 or 1, and P = 2^(8+c) for c = 2..7.
- R2: The reset request lasts one cycle. The count restarts at that edge, so the next request comes P cycles after the previous one.
- R3: Source code 00 counts only cycles with slow_tick_i high. Source code 01 counts every fourth cycle after the restart, so the period is 4P cycles.
- R4: A high clr_i, or any write to the period register (address 0), zeroes the count. The period then restarts from that edge.
- R5: Key 000000 runs the watchdog. Key 101101 holds the count at zero and blocks every timeout request. After the run key is written again, the request comes a full P cycles after that write.
- R6: Any other key value causes a one-cycle reset request in the cycle after the third slow tick seen following the write, and no request before that tick.
- R7: Writing a legal key (run or halt) before the third slow tick cancels the pending key-fault request.
- R8: After reset, address 0 reads 0x07, address 1 reads 0x00, and rst_req_o is low.
- R9: Bits 7..3 of the period register read as zero whatever was written there. Bits 2..0 read back the stored code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select: 0 period, 1 control |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| clr_i | input | 1 | Watchdog clear (kick) |
| slow_tick_i | input | 1 | One-cycle tick from the slow oscillator |
| rst_req_o | output | 1 | One-cycle reset request |

Control register (address 1): bits 7..6 are the source select and bits 5..0 are the key. Period register (address 0): bits 2..0 are the period code.

## Verification
The bench uses the default parameters: an 8-bit minimum exponent, a 3-bit period code, a 15-bit counter and a three-tick fault delay. With these values every period code, up to the 32768-cycle period, can be swept exhaustively on the system-clock source. The divide-by-four source and the slow-tick source are each measured at the shortest period. The key-fault delay is driven tick by tick so that its exact firing cycle and its cancellation can be observed.

// File: rtl/keyed_wdt_pkg.sv
package keyed_wdt_pkg;
  localparam int REG_W = 8;
  localparam int KEY_W = 6;
  localparam logic [KEY_W-1:0] KEY_RUN  = 6'b000000;
  localparam logic [KEY_W-1:0] KEY_HALT = 6'b101101;

  typedef enum logic [1:0] {
    SRC_SLOW  = 2'b00,
    SRC_DIV4  = 2'b01,
    SRC_SYS   = 2'b10,
    SRC_SYS_B = 2'b11
  } src_e;

  // codes 0 and 1 share the shortest period
  function automatic int unsigned period_exp(input int unsigned code, input int unsigned min_exp);
    return (code < 2) ? min_exp : min_exp + code;
  endfunction
endpackage

// File: rtl/wdt_ctrl_regs.sv
module wdt_ctrl_regs
  import keyed_wdt_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic [SEL_W-1:0] per_code_o,
  output src_e             src_o,
  output logic [KEY_W-1:0] key_o,
  output logic             per_wr_o
);
  logic [SEL_W-1:0] per_q;
  src_e             src_q;
  logic [KEY_W-1:0] key_q;

  assign per_wr_o = wr_en_i && !addr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q <= '1;
      src_q <= SRC_SLOW;
      key_q <= KEY_RUN;
    end else if (wr_en_i) begin
      if (!addr_i) per_q <= wdata_i[SEL_W-1:0];
      else begin
        src_q <= src_e'(wdata_i[REG_W-1 -: 2]);
        key_q <= wdata_i[KEY_W-1:0];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (!addr_i) rdata_o[SEL_W-1:0] = per_q;
    else         rdata_o = {src_q, key_q};
  end

  assign per_code_o = per_q;
  assign src_o      = src_q;
  assign key_o      = key_q;

  p_per_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && !addr_i) |=> $stable(per_q));
endmodule

// File: rtl/wdt_tick_mux.sv
module wdt_tick_mux
  import keyed_wdt_pkg::*;
#(
  parameter int PRE_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  src_e src_i,
  input  logic slow_tick_i,
  input  logic restart_i,
  output logic tick_o
);
  localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          pre_q <= '0;
    else if (restart_i || pre_q == PRE_LAST) pre_q <= '0;
    else                                  pre_q <= pre_q + 1'b1;
  end

  always_comb begin
    unique case (src_i)
      SRC_SLOW: tick_o = slow_tick_i;
      SRC_DIV4: tick_o = (pre_q == PRE_LAST);
      default:  tick_o = 1'b1;
    endcase
  end

  p_pre_restart_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> pre_q == '0);
endmodule

// File: rtl/wdt_period_cnt.sv
module wdt_period_cnt #(
  parameter int MIN_EXP = 8,
  parameter int SEL_W   = 3,
  parameter int CNT_W   = MIN_EXP + (1 << SEL_W) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [SEL_W-1:0] code_i,
  output logic             hit_o
);
  import keyed_wdt_pkg::*;

  logic [CNT_W-1:0] cnt_q, mask;
  int unsigned      exp_w;

  always_comb begin
    exp_w = period_exp(int'(code_i), MIN_EXP);
    for (int b = 0; b < CNT_W; b++) mask[b] = (b < int'(exp_w));
  end

  assign hit_o = run_i && tick_i && !clr_i && (cnt_q == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (clr_i || !run_i || hit_o) cnt_q <= '0;
    else if (tick_i)                  cnt_q <= cnt_q + 1'b1;
  end

  p_clear_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
  p_halt_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);
  p_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> cnt_q == '0);
  p_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(code_i) |-> cnt_q <= mask);
endmodule

// File: rtl/wdt_key_guard.sv
module wdt_key_guard #(
  parameter int FAULT_TICKS = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bad_key_i,
  input  logic slow_tick_i,
  output logic fault_o
);
  localparam int FW = $clog2(FAULT_TICKS + 1);
  localparam logic [FW-1:0] F_LAST = FW'(FAULT_TICKS - 1);

  logic [FW-1:0] seen_q;

  assign fault_o = bad_key_i && slow_tick_i && (seen_q == F_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    seen_q <= '0;
    else if (!bad_key_i || fault_o) seen_q <= '0;
    else if (slow_tick_i)           seen_q <= seen_q + 1'b1;
  end

  p_cancel_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bad_key_i |=> seen_q == '0);
  p_no_early_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> bad_key_i && $past(bad_key_i));
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import keyed_wdt_pkg::*;
#(
  parameter int MIN_EXP     = 8,
  parameter int SEL_W       = 3,
  parameter int PRE_DIV     = 4,
  parameter int FAULT_TICKS = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic             clr_i,
  input  logic             slow_tick_i,
  output logic             rst_req_o
);
  localparam int CNT_W = MIN_EXP + (1 << SEL_W) - 1;

  logic [SEL_W-1:0] per_code;
  src_e             src;
  logic [KEY_W-1:0] key;
  logic             per_wr, run, bad_key, restart, tick, tmo_hit, fault, req_q;

  wdt_ctrl_regs #(.SEL_W(SEL_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rdata_o,
    .per_code_o(per_code), .src_o(src), .key_o(key), .per_wr_o(per_wr)
  );

  assign run     = (key == KEY_RUN);
  assign bad_key = !run && (key != KEY_HALT);
  assign restart = clr_i || per_wr;

  wdt_tick_mux #(.PRE_DIV(PRE_DIV)) u_tick (
    .clk_i, .rst_ni, .src_i(src), .slow_tick_i,
    .restart_i(restart || !run || tmo_hit), .tick_o(tick)
  );

  wdt_period_cnt #(.MIN_EXP(MIN_EXP), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .run_i(run), .clr_i(restart), .tick_i(tick),
    .code_i(per_code), .hit_o(tmo_hit)
  );

  wdt_key_guard #(.FAULT_TICKS(FAULT_TICKS)) u_guard (
    .clk_i, .rst_ni, .bad_key_i(bad_key), .slow_tick_i, .fault_o(fault)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= tmo_hit || fault;
  end

  assign rst_req_o = req_q;

  p_one_cycle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);
  p_halt_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key == KEY_HALT) && $past(key == KEY_HALT) |-> !rst_req_o);
endmodule

// File: tb/keyed_wdt_tb_top.sv
module keyed_wdt_tb_top;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       wr_en = 1'b0, addr = 1'b0, clr = 1'b0, slow = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic       rst_req;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  keyed_wdt dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .clr_i(clr), .slow_tick_i(slow), .rst_req_o(rst_req)
  );

  function automatic int per_of(input int code);
    return 1 << ((code < 2) ? 8 : 8 + code);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic kick();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  // cycles from the last restart edge until rst_req_o is seen, or -1
  task automatic measure(input int lim, output int n);
    n = -1;
    for (int i = 1; i <= lim; i++) begin
      @(negedge clk);
      if (rst_req) begin n = i; break; end
    end
  endtask

  task automatic slow_pulse();
    @(negedge clk); slow = 1'b1;
    @(negedge clk); slow = 1'b0;
  endtask

  initial begin
    int n;
    int seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    addr = 1'b0; #1 check("R8 period reset", rdata, 8'h07);
    addr = 1'b1; #1 check("R8 control reset", rdata, 8'h00);
    check("R8 request low", rst_req, 0);

    wr(1'b0, 8'hFA);
    addr = 1'b0; #1 check("R9 high bits zero", rdata, 8'h02);

    // R1 sweep of all period codes on the system clock
    wr(1'b1, 8'h80);
    for (int c = 0; c < 8; c++) begin
      wr(1'b0, 8'(c));
      measure(per_of(c) + 8, n);
      check($sformatf("R1 code %0d", c), n, per_of(c));
    end

    // R2 width and repeat
    wr(1'b0, 8'h01);
    measure(300, n);
    @(negedge clk); check("R2 width", rst_req, 0);
    measure(300, n);
    check("R2 repeat", n + 1, 256);

    // R4 clear mid-count, source code 11
    wr(1'b1, 8'hC0);
    kick();
    repeat (200) @(negedge clk);
    kick();
    measure(300, n);
    check("R4 clear restart", n, 256);

    // R3 divide-by-four
    wr(1'b1, 8'h40);
    wr(1'b0, 8'h00);
    measure(1100, n);
    check("R3 div4", n, 1024);

    // R3 slow source: idle tick means no timeout, steady tick gives P
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h00);
    measure(600, n);
    check("R3 slow idle", n, -1);
    slow = 1'b1;
    wr(1'b0, 8'h00);
    measure(300, n);
    check("R3 slow steady", n, 256);
    @(negedge clk); slow = 1'b0;

    // R5 halt key
    wr(1'b1, 8'hAD);
    measure(700, n);
    check("R5 halted", n, -1);
    wr(1'b1, 8'h80);
    measure(300, n);
    check("R5 resume full period", n, 256);

    // R6 illegal key
    wr(1'b1, 8'h95);
    seen = 0;
    for (int k = 0; k < 2; k++) begin
      slow_pulse(); seen |= rst_req;
      repeat (2) begin @(negedge clk); seen |= rst_req; end
    end
    check("R6 no early request", seen, 0);
    slow_pulse();
    check("R6 request after third tick", rst_req, 1);
    @(negedge clk); check("R6 width", rst_req, 0);

    // R7 cancel by run key and by halt key
    wr(1'b1, 8'h80);
    wr(1'b1, 8'h95);
    slow_pulse(); slow_pulse();
    wr(1'b1, 8'h80);
    seen = 0;
    repeat (4) begin slow_pulse(); seen |= rst_req; end
    check("R7 cancel by run key", seen, 0);
    wr(1'b1, 8'h95);
    slow_pulse(); slow_pulse();
    wr(1'b1, 8'hAD);
    seen = 0;
    repeat (4) begin slow_pulse(); seen |= rst_req; end
    check("R7 cancel by halt key", seen, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule